// File: doc/BRIEF.md
# Single-to-Narrow Float Down-Converter

This block narrows a 32-bit single-precision value (1 sign, 8 exponent and 23 mantissa bits) to one of three smaller floating-point encodings. A two-bit select input chooses the target for each sample. The targets are a 16-bit half format (1/5/10, bias 15), a 16-bit brain-float format (1/8/7, bias 127) and an 8-bit format (1/4/3, bias 7). The 8-bit result sits in the low byte of a 16-bit output bus, and the upper byte is zero.

The block has a single register stage. A sample that is presented with its valid bit is registered on the next clock edge, together with four status flags: overflow, underflow to zero, inexact and subnormal result. Rounding is round-to-nearest, ties-to-even, for every target. If the mantissa carries out during rounding, the exponent goes up by one. The targets handle overflow differently. The half and brain-float targets overflow to a signed infinity. The 8-bit target has no infinity encoding, so it saturates to ±448. Results too small for a normal encoding are produced as subnormals. Results below half of the smallest subnormal become a signed zero.

Top module: `fp_narrow_cvt`

## Requirements
- R1: While reset is held low, out_valid, dout and all four flags are zero.
- R2: out_valid equals in_valid from one clock earlier. dout and the flags hold the result of the sample taken at that earlier edge.
- R3: All three targets round to nearest with ties to even, and a mantissa carry increments the exponent. For example, pi (0x40490FDB) converts to 0x4248 (3.140625) in the half format, and 0x3F803000 converts to 0x3C02.
- R4: In the half format (fmt=0), 65504 converts to 0x7BFF. Any finite input that rounds above that value gives a signed infinity (0x7C00 with the sign in bit 15) and raises flg_ovf.
- R5: In the half format, a result below 2^-14 is encoded as a subnormal and raises flg_subn. A result that rounds to zero is a signed zero and raises flg_unf. An input of 1e-8 therefore gives zero in both the half and the 8-bit formats.
- R6: In the brain-float format (fmt=1), a finite input overflows only when rounding carries past the largest binade. Small inputs such as 1e-8 stay nonzero.
- R7: In the 8-bit format (fmt=2), an overflowing finite input saturates to magnitude 0x7E (448) and raises flg_ovf. An input NaN or infinity gives 0x7F with the input sign in bit 7.
- R8: In the 16-bit formats, a NaN input gives a quiet NaN: 0x7E00 for half and 0x7FC0 for brain-float, each with the input sign in bit 15. An infinity input gives infinity with its sign. Special inputs raise no flag.
- R9: The sign of zero is preserved. The 8-bit result puts its sign in bit 7 and drives bits 15:8 to zero.
- R10: The reserved select code fmt=3 gives dout=0 with all flags low.
- R11: flg_inexact is set whenever the result differs from the input value, which includes every overflow and every underflow. flg_ovf, flg_unf and flg_subn are mutually exclusive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Sample present on din and fmt |
| fmt | input | 2 | Target: 0 half, 1 brain-float, 2 8-bit, 3 reserved |
| din | input | 32 | Single-precision input |
| out_valid | output | 1 | Registered result valid |
| dout | output | 16 | Converted value, zero-extended |
| flg_ovf | output | 1 | Overflow (infinity or saturation) |
| flg_unf | output | 1 | Nonzero input rounded to zero |
| flg_inexact | output | 1 | Result not exact |
| flg_subn | output | 1 | Result is a nonzero subnormal |

## Verification
Every result and every flag is due exactly one clock edge after the edge that captures the sample. The bench drives each sample on a falling edge and holds it across one rising edge. It compares dout, the flags and out_valid on the next falling edge, so each output is read one register after its input, half a cycle clear of any edge. A separate idle cycle with in_valid low checks that out_valid drops on the following edge.

// File: rtl/fp_narrow_cvt.sv
module fp_narrow_cvt (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  input  logic [1:0]  fmt,
  input  logic [31:0] din,
  output logic        out_valid,
  output logic [15:0] dout,
  output logic        flg_ovf,
  output logic        flg_unf,
  output logic        flg_inexact,
  output logic        flg_subn
);
  localparam logic [1:0] F_HALF = 2'd0;
  localparam logic [1:0] F_BRAIN = 2'd1;
  localparam logic [1:0] F_E4M3 = 2'd2;

  wire        sgn  = din[31];
  wire [7:0]  ein  = din[30:23];
  wire        spec = (ein == 8'hFF);
  wire        nan  = spec && (din[22:0] != 23'd0);
  wire [23:0] sig  = {ein != 8'd0, din[22:0]};

  int          mw, bias, tei, shi;
  logic [50:0] ext;
  logic [23:0] kp;
  logic        g, st, rnd, ovf;
  logic [19:0] pk;
  logic [15:0] res;
  logic [3:0]  fl;

  always_comb begin
    case (fmt)
      F_HALF:  begin mw = 10; bias = 15;  end
      F_BRAIN: begin mw = 7;  bias = 127; end
      default: begin mw = 3;  bias = 7;   end
    endcase
    tei = int'((ein == 8'd0) ? 8'd1 : ein) - 127 + bias;
    shi = 23 - mw + ((tei < 1) ? 1 - tei : 0);
    if (shi > 27) shi = 27;
    ext = {sig, 27'd0} >> shi;
    kp  = ext[50:27];
    g   = ext[26];
    st  = |ext[25:0];
    rnd = g & (st | kp[0]);
    pk  = ((tei >= 1) ? (20'(tei - 1) << mw) : 20'd0) + 20'(kp) + 20'(rnd);
    ovf = 1'b0;
    res = 16'd0;
    case (fmt)
      F_HALF: begin
        if (spec)                 res = {sgn, nan ? 15'h7E00 : 15'h7C00};
        else if (pk >= 20'h7C00) begin res = {sgn, 15'h7C00}; ovf = 1'b1; end
        else                      res = {sgn, pk[14:0]};
      end
      F_BRAIN: begin
        if (spec)                 res = {sgn, nan ? 15'h7FC0 : 15'h7F80};
        else if (pk >= 20'h7F80) begin res = {sgn, 15'h7F80}; ovf = 1'b1; end
        else                      res = {sgn, pk[14:0]};
      end
      F_E4M3: begin
        if (spec)                 res = {8'h00, sgn, 7'h7F};
        else if (pk > 20'h7E)    begin res = {8'h00, sgn, 7'h7E}; ovf = 1'b1; end
        else                      res = {8'h00, sgn, pk[6:0]};
      end
      default: res = 16'd0;
    endcase
    if (spec || fmt == 2'd3) fl = 4'd0;
    else fl = {ovf,
               (pk == 20'd0) && (din[30:0] != 31'd0),
               g | st | ovf,
               !ovf && (pk != 20'd0) && (pk < (20'd1 << mw))};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      dout      <= 16'd0;
      {flg_ovf, flg_unf, flg_inexact, flg_subn} <= 4'd0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        dout <= res;
        {flg_ovf, flg_unf, flg_inexact, flg_subn} <= fl;
      end
    end
  end
endmodule

// File: rtl/fp_narrow_cvt_chk.sv
module fp_narrow_cvt_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic [1:0]  fmt,
  input logic [31:0] din,
  input logic        out_valid,
  input logic [15:0] dout,
  input logic        flg_ovf,
  input logic        flg_unf,
  input logic        flg_inexact,
  input logic        flg_subn
);
  a_r2_valid_pipe: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  a_r2_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  a_r4_half_ovf_inf: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && $past(fmt) == 2'd0 && flg_ovf) |-> dout[14:0] == 15'h7C00);
  a_r5_half_unf_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && $past(fmt) == 2'd0 && flg_unf) |-> dout[14:0] == 15'd0);
  a_r7_e4m3_sat: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && $past(fmt) == 2'd2 && flg_ovf) |-> dout[6:0] == 7'h7E);
  a_r9_e4m3_zext: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && $past(fmt) == 2'd2) |-> dout[15:8] == 8'd0);
  a_r10_reserved: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && $past(fmt) == 2'd3) |->
      (dout == 16'd0 && !flg_ovf && !flg_unf && !flg_inexact && !flg_subn));
  a_r11_flag_excl: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({flg_ovf, flg_unf, flg_subn}));
  a_r11_lossy_inexact: assert property (@(posedge clk) disable iff (!rst_n)
    (flg_ovf || flg_unf) |-> flg_inexact);
  wire unused_ok = &{1'b0, din};
endmodule

bind fp_narrow_cvt fp_narrow_cvt_chk u_chk (.*);

// File: tb/tb_fp_narrow_cvt.sv
module tb_fp_narrow_cvt;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [1:0]  fmt = 2'd0;
  logic [31:0] din = 32'd0;
  logic        out_valid, flg_ovf, flg_unf, flg_inexact, flg_subn;
  logic [15:0] dout;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  fp_narrow_cvt dut (.clk(clk), .rst_n(rst_n), .in_valid(in_valid), .fmt(fmt),
    .din(din), .out_valid(out_valid), .dout(dout), .flg_ovf(flg_ovf),
    .flg_unf(flg_unf), .flg_inexact(flg_inexact), .flg_subn(flg_subn));

  // returns {ovf, unf, inexact, subn, result}
  function automatic logic [19:0] model(input logic [1:0] f, input logic [31:0] x);
    int mb, bs, eb, ex, e, emin, qe, d, expf;
    longint n, mant;
    bit g, st, ov, s;
    logic [15:0] r;
    logic [3:0] fl;
    if (f == 2'd3) return 20'd0;
    s = x[31];
    case (f)
      2'd0: begin mb = 10; bs = 15; eb = 5; end
      2'd1: begin mb = 7; bs = 127; eb = 8; end
      default: begin mb = 3; bs = 7; eb = 4; end
    endcase
    ex = int'(x[30:23]);
    if (ex == 255) begin
      if (f == 2'd2) r = {8'h00, s, 7'h7F};
      else if (x[22:0] != 0) r = {s, (f == 2'd0) ? 15'h7E00 : 15'h7FC0};
      else r = {s, (f == 2'd0) ? 15'h7C00 : 15'h7F80};
      return {4'd0, r};
    end
    n = longint'({ex != 0, x[22:0]});
    e = (ex == 0) ? -126 : ex - 127;
    emin = 1 - bs;
    d = 23 - mb + ((emin > e) ? emin - e : 0);
    g = 0; st = 0;
    for (int i = 0; i < d; i++) begin
      st = st | g;
      g = n[0];
      n = n >> 1;
    end
    qe = ((e > emin) ? e : emin) - mb;
    if (g && (st || n[0])) n = n + 1;
    if (n == (longint'(1) << (mb + 1))) begin n = longint'(1) << mb; qe = qe + 1; end
    if (n >= (longint'(1) << mb)) begin expf = qe + mb + bs; mant = n - (longint'(1) << mb); end
    else begin expf = 0; mant = n; end
    if (f == 2'd2) ov = (expf > 15) || (expf == 15 && mant == 7);
    else ov = expf >= (1 << eb) - 1;
    if (ov) begin
      if (f == 2'd0) r = {s, 15'h7C00};
      else if (f == 2'd1) r = {s, 15'h7F80};
      else r = {8'h00, s, 7'h7E};
    end else if (f == 2'd2) r = {8'h00, s, 4'(expf), 3'(mant)};
    else if (f == 2'd0) r = {s, 5'(expf), 10'(mant)};
    else r = {s, 8'(expf), 7'(mant)};
    fl[3] = ov;
    fl[2] = (n == 0) && (x[30:0] != 0);
    fl[1] = g | st | ov;
    fl[0] = !ov && expf == 0 && mant != 0;
    return {fl, r};
  endfunction

  task automatic chk(input string tag, input logic [19:0] act, input logic [19:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s fmt=%0d din=%h actual flags=%b dout=%h expected flags=%b dout=%h",
               tag, fmt, din, act[19:16], act[15:0], exp[19:16], exp[15:0]);
    end
  endtask

  task automatic conv(input string tag, input logic [1:0] f, input logic [31:0] x);
    @(negedge clk);
    in_valid = 1'b1; fmt = f; din = x;
    @(negedge clk);
    chk(tag, {flg_ovf, flg_unf, flg_inexact, flg_subn, dout}, model(f, x));
    if (out_valid !== 1'b1) begin
      checks++; errors++;
      $display("FAIL R2 out_valid actual=%b expected=1", out_valid);
    end
    in_valid = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    chk("R1", {out_valid, flg_ovf, flg_unf, flg_inexact, flg_subn, dout[14:0]}, 20'd0);
    rst_n = 1'b1;

    conv("R3", 2'd0, 32'h40490FDB);
    chk("R3", {4'd0, dout}, {4'd0, 16'h4248});
    conv("R3", 2'd0, 32'h3F801000);
    conv("R3", 2'd0, 32'h3F803000);
    chk("R3", {4'd0, dout}, {4'd0, 16'h3C02});
    conv("R3", 2'd1, 32'h40490FDB);
    conv("R3", 2'd2, 32'h43E80000);
    conv("R4", 2'd0, 32'h477FE000);
    chk("R4", {4'd0, dout}, {4'd0, 16'h7BFF});
    conv("R4", 2'd0, 32'h477FF000);
    conv("R4", 2'd0, 32'hC7C35000);
    chk("R4", {4'd0, dout}, {4'd0, 16'hFC00});
    conv("R5", 2'd0, 32'h322BCC77);
    chk("R5", {flg_unf, 3'd0, dout}, {1'b1, 3'd0, 16'h0000});
    conv("R5", 2'd2, 32'h322BCC77);
    conv("R5", 2'd0, 32'h33800000);
    chk("R5", {flg_subn, 3'd0, dout}, {1'b1, 3'd0, 16'h0001});
    conv("R5", 2'd0, 32'h33000000);
    conv("R5", 2'd0, 32'h33000001);
    conv("R5", 2'd0, 32'h38800000);
    conv("R5", 2'd0, 32'h387FFFFF);
    conv("R6", 2'd1, 32'h322BCC77);
    chk("R6", {4'd0, dout}, {4'd0, 16'h322C});
    conv("R6", 2'd1, 32'h7F7FFFFF);
    conv("R6", 2'd1, 32'h7F7F7FFF);
    conv("R6", 2'd1, 32'h00400000);
    conv("R6", 2'd1, 32'h00000001);
    conv("R7", 2'd2, 32'h43E00000);
    chk("R7", {4'd0, dout}, {4'd0, 16'h007E});
    conv("R7", 2'd2, 32'h43F00000);
    conv("R7", 2'd2, 32'hC9742400);
    chk("R7", {flg_ovf, 3'd0, dout}, {1'b1, 3'd0, 16'h00FE});
    conv("R7", 2'd2, 32'hFF800000);
    chk("R7", {4'd0, dout}, {4'd0, 16'h00FF});
    conv("R7", 2'd2, 32'h7FC00000);
    conv("R7", 2'd2, 32'h3B000000);
    conv("R8", 2'd0, 32'hFFC00001);
    chk("R8", {4'd0, dout}, {4'd0, 16'hFE00});
    conv("R8", 2'd1, 32'h7F800001);
    chk("R8", {4'd0, dout}, {4'd0, 16'h7FC0});
    conv("R8", 2'd0, 32'h7F800000);
    conv("R8", 2'd1, 32'hFF800000);
    conv("R9", 2'd0, 32'h80000000);
    chk("R9", {4'd0, dout}, {4'd0, 16'h8000});
    conv("R9", 2'd1, 32'h80000000);
    conv("R9", 2'd2, 32'h80000000);
    chk("R9", {4'd0, dout}, {4'd0, 16'h0080});
    conv("R10", 2'd3, 32'h40490FDB);
    conv("R10", 2'd3, 32'hFF800000);
    conv("R11", 2'd1, 32'h3F800001);
    chk("R11", {flg_inexact, 3'd0, dout}, {1'b1, 3'd0, 16'h3F80});

    @(negedge clk);
    checks++;
    if (out_valid !== 1'b0) begin
      errors++;
      $display("FAIL R2 idle out_valid actual=%b expected=0", out_valid);
    end

    for (int i = 0; i < 3000; i++) begin
      logic [31:0] x;
      logic [1:0] f;
      x = $urandom;
      f = 2'($urandom % 3);
      if (i % 2 == 0) begin
        case (f)
          2'd0: x[30:23] = 8'(8'd97 + 8'($urandom % 50));
          2'd1: x[30:23] = ($urandom % 2 == 0) ? 8'(8'd254 - 8'($urandom % 4)) : 8'($urandom % 4);
          default: x[30:23] = 8'(8'd113 + 8'($urandom % 30));
        endcase
      end
      conv("R3", f, x);
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule